// File: doc/BRIEF.md
# Coherency Unit Control Register Block

This block is the software-visible register file of a multicore coherency unit. It sits behind a simple memory-mapped slave port that carries an address, a byte-count indication, write data and separate read and write strobes. Only two pieces of state are kept:

- a one-bit enable flag;
- a 32-bit word of per-core power-status bytes. Any byte of this word can be reached through its own sub-offset, so a core can update its own byte without disturbing the bytes of its neighbours.

A read-only configuration word is built from the core-count parameter. Several further offsets answer reads with zero and drop writes, so that driver code written for larger configurations keeps working: the secure invalidate-all command, the two address-filter bounds and the two access-control words.

The port is a plain strobe interface with no back-pressure. A write completes in the cycle its strobe is sampled. A read always returns data with a valid flag exactly one clock after its strobe, so the port never stalls. A write whose byte-count code is not 1, 2 or 4 is rejected and raises a one-cycle error pulse.

Top module: `snoop_regblock`

## Requirements
- R1: While reset is asserted the enable flag and the status word clear to zero, and `rvalid` and `err` are low; after reset, reads of offsets 0x00 and 0x08 return zero.
- R2: A valid write to offset 0x00 stores bit 0 of `wdata` as the enable flag. A read of 0x00 returns that flag in bit 0 and zero in bits 31:1.
- R3: A read of offset 0x04 returns `((2**NUM_CPU)-1) << 4 | (NUM_CPU-1)`. Writes to 0x04 change no readable value.
- R4: A read at offset 0x08+k (k = 0..3) returns the status word shifted right by 8·k bits, filled with zeros from the top.
- R5: A valid write at offset 0x08+k replaces the status bits selected by `mask << 8k` with `(wdata & mask) << 8k`, truncated to 32 bits. The mask is 0xFF for size code 1, 0xFFFF for code 2 and 0xFFFFFFFF for code 4. All other status bits keep their value.
- R6: A write whose `size` code is not 1, 2 or 4 changes no state. It drives `err` high for exactly the one cycle after the write strobe is sampled. `err` is low in every other cycle.
- R7: Offsets 0x0C, 0x40, 0x44, 0x50 and 0x54 read as zero, and writes to them leave the enable flag and the status word unchanged.
- R8: Every offset not named in R2 to R7 reads as zero, and writes to it change no state.
- R9: `rvalid` is high in the cycle after `rd_en` is sampled and low otherwise. `rdata` then holds the value as it stood before any write sampled in the same cycle as the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte offset of the access |
| size | input | 3 | Byte count of a write: 1, 2 or 4 |
| wdata | input | 32 | Write data, low-aligned |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | High one cycle after a read strobe |
| err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The hardest case to reach from the ports is a partial write at an upper status sub-offset whose mask runs past bit 31, such as a 4-byte write at 0x0A. There the truncation and the preservation of the lower lanes both matter at once. The bench sweeps every lane offset against every size code, valid and invalid, with varied data. After each write it reads all four lanes back, so any bit disturbed outside the mask is seen. A full sweep that writes and reads every address confirms that only the mapped offsets hold state.

// File: rtl/snreg_pkg.sv
package snreg_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = LANES * 8;
  localparam int SIZE_W = 3;

  typedef enum logic [2:0] {
    RGN_CTRL,
    RGN_CFG,
    RGN_STAT,
    RGN_INVAL,
    RGN_FILT,
    RGN_ACC,
    RGN_NONE
  } region_e;

  function automatic logic size_valid(input logic [SIZE_W-1:0] s);
    return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [SIZE_W-1:0] s);
    case (s)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd4:    return 32'hFFFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/snreg_decode.sv
module snreg_decode
  import snreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [1:0]        lane
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_STAT1 = ADDR_W'(8'h09);
  localparam logic [ADDR_W-1:0] A_STAT2 = ADDR_W'(8'h0A);
  localparam logic [ADDR_W-1:0] A_STAT3 = ADDR_W'(8'h0B);
  localparam logic [ADDR_W-1:0] A_INVAL = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_FLO   = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_FHI   = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] A_ACC   = ADDR_W'(8'h50);
  localparam logic [ADDR_W-1:0] A_ACCNS = ADDR_W'(8'h54);

  always_comb begin
    lane = addr[1:0];
    case (addr)
      A_CTRL:                             region = RGN_CTRL;
      A_CFG:                              region = RGN_CFG;
      A_STAT0, A_STAT1, A_STAT2, A_STAT3: region = RGN_STAT;
      A_INVAL:                            region = RGN_INVAL;
      A_FLO, A_FHI:                       region = RGN_FILT;
      A_ACC, A_ACCNS:                     region = RGN_ACC;
      default:                            region = RGN_NONE;
    endcase
  end
endmodule

// File: rtl/snreg_state.sv
module snreg_state
  import snreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  region_e           region,
  input  logic [1:0]        lane,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctrl_q,
  output logic [DATA_W-1:0] status_q,
  output logic              err_q
);
  logic              size_ok;
  logic              wr_go;
  logic [4:0]        shamt;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] lane_data;
  logic [DATA_W-1:0] status_d;
  logic              ctrl_d;

  assign size_ok   = size_valid(size);
  assign wr_go     = wr_en && size_ok;
  assign shamt     = {lane, 3'b000};
  assign lane_mask = size_mask(size) << shamt;
  assign lane_data = (wdata & size_mask(size)) << shamt;

  always_comb begin
    status_d = status_q;
    ctrl_d   = ctrl_q;
    if (wr_go && region == RGN_STAT)
      status_d = (status_q & ~lane_mask) | lane_data;
    if (wr_go && region == RGN_CTRL)
      ctrl_d = wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= 1'b0;
      status_q <= '0;
      err_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      status_q <= status_d;
      err_q    <= wr_en && !size_ok;
    end
  end

  // R6
  bad_size_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !size_ok) |=> (err_q && $stable(status_q) && $stable(ctrl_q)));
  // R6
  no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !err_q);
  // R7
  status_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region != RGN_STAT) |=> $stable(status_q));
  // R8
  ctrl_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region != RGN_CTRL) |=> $stable(ctrl_q));
  // R5
  lane_preserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size_ok && region == RGN_STAT) |=>
      (((status_q ^ $past(status_q)) & ~$past(lane_mask)) == '0));
endmodule

// File: rtl/snreg_rdpath.sv
module snreg_rdpath
  import snreg_pkg::*;
#(
  parameter int NUM_CPU = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  region_e           region,
  input  logic [1:0]        lane,
  input  logic              ctrl_q,
  input  logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int MAX_CPU = 4;

  logic [MAX_CPU-1:0] cpu_present;
  logic [DATA_W-1:0]  cfg_word;
  logic [DATA_W-1:0]  rd_mux;

  for (genvar c = 0; c < MAX_CPU; c++) begin : g_present
    assign cpu_present[c] = (c < NUM_CPU);
  end

  assign cfg_word = {{(DATA_W-8){1'b0}}, cpu_present, 2'b00, 2'(NUM_CPU - 1)};

  always_comb begin
    case (region)
      RGN_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, ctrl_q};
      RGN_CFG:  rd_mux = cfg_word;
      RGN_STAT: rd_mux = status_q >> {lane, 3'b000};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R9
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  // R9
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  // R8
  empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && region inside {RGN_INVAL, RGN_FILT, RGN_ACC, RGN_NONE}) |=> (rdata == '0));
  // R2
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && region == RGN_CTRL) |=> (rdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/snoop_regblock.sv
module snoop_regblock
  import snreg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_CPU = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              err
);
  region_e           region;
  logic [1:0]        lane;
  logic              ctrl_q;
  logic [DATA_W-1:0] status_q;

  snreg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (addr),
    .region (region),
    .lane   (lane)
  );

  snreg_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .region   (region),
    .lane     (lane),
    .size     (size),
    .wdata    (wdata),
    .ctrl_q   (ctrl_q),
    .status_q (status_q),
    .err_q    (err)
  );

  snreg_rdpath #(.NUM_CPU(NUM_CPU)) u_rdpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .region   (region),
    .lane     (lane),
    .ctrl_q   (ctrl_q),
    .status_q (status_q),
    .rdata    (rdata),
    .rvalid   (rvalid)
  );
endmodule

// File: tb/snoop_regblock_test.sv
module snoop_regblock_test;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [2:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        err;

  int checks = 0;
  int errors = 0;
  logic        m_ctrl = 1'b0;
  logic [31:0] m_stat = '0;
  logic [31:0] got;
  logic [31:0] old_stat;

  always #5 clk = ~clk;

  snoop_regblock #(.ADDR_W(8), .NUM_CPU(N)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .size(size), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  function automatic logic [31:0] cfg_exp();
    return (((32'd1 << N) - 32'd1) << 4) | 32'(N - 1);
  endfunction

  function automatic logic [31:0] rd_exp(input int a);
    if (a == 0) return {31'b0, m_ctrl};
    if (a == 4) return cfg_exp();
    if (a >= 8 && a <= 11) return m_stat >> (8 * (a - 8));
    return 32'h0;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [2:0] s, input logic [31:0] d);
    logic        bad;
    logic [31:0] mk;
    bad = !(s == 3'd1 || s == 3'd2 || s == 3'd4);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'(a); size = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    check(err == bad, "R6 err", {31'b0, err}, {31'b0, bad});
    if (!bad) begin
      mk = (s == 3'd1) ? 32'hFF : (s == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
      if (a == 0) m_ctrl = d[0];
      if (a >= 8 && a <= 11)
        m_stat = (m_stat & ~(mk << (8 * (a - 8)))) | ((d & mk) << (8 * (a - 8)));
    end
  endtask

  task automatic do_read(input int a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = 8'(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(rvalid == 1'b1, "R9 rvalid", {31'b0, rvalid}, 32'd1);
    v = rdata;
  endtask

  task automatic read_chk(input int a, input string req);
    logic [31:0] v;
    do_read(a, v);
    check(v == rd_exp(a), req, v, rd_exp(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rvalid == 1'b0 && err == 1'b0, "R1 outputs in reset", {30'b0, rvalid, err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rvalid == 1'b0, "R1 idle rvalid", {31'b0, rvalid}, 32'd0);
    read_chk(0, "R1 ctrl after reset");
    read_chk(8, "R1 status after reset");

    // R3 configuration word, write ignored
    read_chk(4, "R3 config");
    do_write(4, 3'd4, 32'hFFFF_FFFF);
    read_chk(4, "R3 config after write");

    // R2 enable flag keeps bit 0 only
    do_write(0, 3'd4, 32'hFFFF_FFFE);
    read_chk(0, "R2 ctrl cleared");
    do_write(0, 3'd1, 32'h0000_0003);
    read_chk(0, "R2 ctrl set");

    // R4 R5 R6 sweep lanes x size codes x data
    do_write(8, 3'd4, 32'h5A5A_5A5A);
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 8; s++)
        for (int i = 0; i < 3; i++) begin
          do_write(8 + k, 3'(s), 32'h9E37_79B9 * 32'(k * 64 + s * 8 + i + 1));
          for (int j = 0; j < 4; j++) read_chk(8 + j, "R5 R4 lane readback");
        end

    // R6 error pulse lasts one cycle
    do_write(8, 3'd3, 32'h1234_5678);
    @(negedge clk);
    check(err == 1'b0, "R6 err single cycle", {31'b0, err}, 32'd0);
    read_chk(8, "R6 state unchanged");

    // R7 stateless offsets
    old_stat = m_stat;
    do_write(12, 3'd4, 32'hFFFF_FFFF);
    do_write(64, 3'd4, 32'hFFFF_FFFF);
    do_write(68, 3'd2, 32'hFFFF_FFFF);
    do_write(80, 3'd4, 32'hFFFF_FFFF);
    do_write(84, 3'd1, 32'hFFFF_FFFF);
    read_chk(12, "R7 invalidate reads zero");
    read_chk(64, "R7 filter lo zero");
    read_chk(68, "R7 filter hi zero");
    read_chk(80, "R7 access zero");
    read_chk(84, "R7 ns access zero");
    do_read(8, got);
    check(got == old_stat, "R7 status unchanged", got, old_stat);

    // R8 full address sweep
    for (int a = 0; a < 256; a++) begin
      do_write(a, 3'd4, 32'hC3A5_0000 | 32'(a * 257));
      read_chk(a, "R8 address sweep");
      read_chk(0, "R8 ctrl after sweep write");
      read_chk(8, "R8 status after sweep write");
    end

    // R9 read sees pre-write value in same cycle
    do_write(8, 3'd4, 32'h1111_2222);
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 8'h08; size = 3'd4; wdata = 32'hABCD_EF01;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check(rdata == 32'h1111_2222, "R9 read before write", rdata, 32'h1111_2222);
    check(rvalid == 1'b1, "R9 rvalid with write", {31'b0, rvalid}, 32'd1);
    m_stat = 32'hABCD_EF01;
    @(negedge clk);
    check(rvalid == 1'b0, "R9 rvalid drops", {31'b0, rvalid}, 32'd0);
    read_chk(8, "R9 write landed");

    // R1 reset in mid-run
    do_write(0, 3'd4, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_ctrl = 1'b0; m_stat = '0;
    read_chk(0, "R1 ctrl after reset pulse");
    read_chk(8, "R1 status after reset pulse");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule